// File: doc/BRIEF.md
# ADC Result Block Transfer Controller

This block moves converter results into memory without processor help. Each pulse on the result-valid input carries one 16-bit sample. The controller turns that sample into one word write on a valid/ready memory write port. The write goes to a pointer that starts at a programmable start address and steps by two bytes per word. A programmable transfer count sets how many words make up a block. At the end of every block the controller emits a one-cycle block-complete pulse, which the surrounding logic uses to set the converter's interrupt flag in place of a per-sample flag.

Two buffering layouts are available. In single-block mode one region is filled. In dual-block mode two regions sit back to back, and a status output tells which of them was filled last. Either layout runs once or continuously. A continuous run returns to the start address after the last block and carries on. A run ends at the next final-block boundary once the continuous bit is cleared, or at once when the start address is rewritten.

A sample that arrives while the previous word is still waiting on the memory port is dropped and sets a sticky overrun flag.

The sequencer has four states:
- OFF: the transfer count is zero.
- WAIT: armed and waiting for a sample.
- WRITE: a word is offered on the memory port.
- DONE: a one-shot run has finished.

Its transitions:
- OFF to WAIT when the count becomes non-zero. This rewinds the pointer.
- WAIT to OFF when the count becomes zero.
- WAIT to WRITE when a sample arrives.
- WRITE to WAIT on a handshake, unless this was the run's final block with the continuous bit clear.
- WRITE to DONE on that last handshake.
- Any state to WAIT, or to OFF if the count is zero, on a start-address write.

Top module: `adc_xfer_ctl`

## Requirements
- R1: After reset `mem_valid`, `blk_done`, `overrun`, `last_blk` and `active` are low, the state is OFF, and the start address is 0x0200.
- R2: While `cfg_count` is 0 the controller is in OFF, `active` is low and samples are ignored. When the count becomes non-zero it re-arms with the pointer, word counter and block index reset to the start address, zero and zero.
- R3: When a sample is taken in WAIT, `mem_valid` rises in the next cycle with `mem_data` equal to the sample and `mem_addr` equal to the pointer. Both are held stable until `mem_ready`, and each completed write advances the pointer by 2.
- R4: A block is `cfg_count` completed writes. `blk_done` is a one-cycle pulse in the cycle after the handshake of a block's last write, and it never follows any other write.
- R5: In single-block mode with `cfg_cont`=0, the run stops (state DONE, `active` low) after one block. Later samples produce no write until the start address is written.
- R6: With `cfg_dual`=1, the second block continues at the address after the first. `last_blk` is 0 after the first block completes and 1 after the second. The pointer then returns to the start address, and with `cfg_cont`=0 the run stops after two blocks.
- R7: With `cfg_cont`=1, the pointer returns to the start address after the final block and transfers go on. If the bit is cleared, the run stops at the next final-block completion.
- R8: A `base_wr` pulse loads `base_wdata` as the start address and pointer. It clears the word counter, the block index, `last_blk` and `overrun`, and abandons any pending write. The controller then arms (WAIT) if `cfg_count` is non-zero, and otherwise enters OFF.
- R9: A sample arriving while `mem_valid` is high is dropped and sets `overrun`. `overrun` stays set until reset or a start-address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_count | input | 8 | Words per block; 0 disables |
| cfg_dual | input | 1 | 1 selects two back-to-back blocks |
| cfg_cont | input | 1 | 1 selects continuous operation |
| base_wr | input | 1 | Start-address write strobe |
| base_wdata | input | 16 | New start address |
| res_valid | input | 1 | Sample-valid strobe |
| res_data | input | 16 | Sample value |
| mem_valid | output | 1 | Write request |
| mem_addr | output | 16 | Write byte address |
| mem_data | output | 16 | Write word |
| mem_ready | input | 1 | Memory accepts the write |
| blk_done | output | 1 | Block-complete pulse |
| last_blk | output | 1 | Index of the block filled last |
| overrun | output | 1 | Sticky dropped-sample flag |
| active | output | 1 | High in WAIT or WRITE |

## Verification
A sample strobed before clock edge k appears on the memory port after edge k. With `mem_ready` high it is accepted at edge k+1, and `blk_done`, `last_blk` and the updated pointer become visible after that same edge k+1. An overrun shows one edge after the colliding strobe. A count change or a start-address write takes effect at the next edge. Inputs are driven on the falling edge. Port values are checked on the falling edge that follows the edge where they are due. Handshakes and block pulses are counted from values sampled at the rising edge, before that edge updates them, so the totals in each check cover exactly the writes a scenario has produced.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;

    typedef enum logic [1:0] {
        XS_OFF   = 2'd0,
        XS_WAIT  = 2'd1,
        XS_WRITE = 2'd2,
        XS_DONE  = 2'd3
    } xfer_state_e;

    localparam int unsigned XFER_AW      = 16;
    localparam int unsigned XFER_DW      = 16;
    localparam int unsigned XFER_CW      = 8;
    localparam int unsigned XFER_STEP    = 2;
    localparam logic [15:0] XFER_BASE_RV = 16'h0200;

endpackage

// File: rtl/adc_xfer_ptr.sv
// Address pointer, word counter and block index for the transfer engine.
module adc_xfer_ptr #(
    parameter int unsigned AW      = 16,
    parameter int unsigned CW      = 8,
    parameter int unsigned STEP    = 2,
    parameter logic [AW-1:0] BASE_RV = 16'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          rewind,
    input  logic          adv,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_dual,
    output logic [AW-1:0] ptr,
    output logic          blk_idx,
    output logic          blk_end,
    output logic          run_end
);
    localparam logic [CW:0]   CNT_ONE = (CW+1)'(1);
    localparam logic [AW-1:0] ADDR_STEP = AW'(STEP);

    logic [AW-1:0] base_q;
    logic [AW-1:0] ptr_q;
    logic [CW-1:0] cnt_q;
    logic          blk_q;
    logic [CW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + CNT_ONE;
    assign blk_end = (cnt_inc >= {1'b0, cfg_count});
    assign run_end = blk_end && (!cfg_dual || blk_q);
    assign ptr     = ptr_q;
    assign blk_idx = blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= BASE_RV;
            ptr_q  <= BASE_RV;
            cnt_q  <= '0;
            blk_q  <= 1'b0;
        end else if (load) begin
            base_q <= load_addr;
            ptr_q  <= load_addr;
            cnt_q  <= '0;
            blk_q  <= 1'b0;
        end else if (rewind) begin
            ptr_q  <= base_q;
            cnt_q  <= '0;
            blk_q  <= 1'b0;
        end else if (adv) begin
            if (run_end) begin
                ptr_q <= base_q;
                cnt_q <= '0;
                blk_q <= 1'b0;
            end else if (blk_end) begin
                ptr_q <= ptr_q + ADDR_STEP;
                cnt_q <= '0;
                blk_q <= 1'b1;
            end else begin
                ptr_q <= ptr_q + ADDR_STEP;
                cnt_q <= cnt_inc[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/adc_xfer_flag.sv
// Sticky flag: set wins over hold, clear wins over set.
module adc_xfer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (set) q <= 1'b1;
    end
endmodule

// File: rtl/adc_xfer_fsm.sv
// Transfer sequencer: state register, next-state logic and registered outputs.
module adc_xfer_fsm
    import adc_xfer_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic          cfg_zero,
    input  logic          cfg_cont,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic          mem_ready,
    input  logic          blk_end,
    input  logic          run_end,
    input  logic          blk_idx,
    output logic          mem_valid,
    output logic [DW-1:0] mem_data,
    output logic          adv,
    output logic          rewind,
    output logic          drop,
    output logic          blk_done,
    output logic          last_blk,
    output logic          active
);
    xfer_state_e   state_q, state_d;
    logic [DW-1:0] data_q;
    logic          take;

    // next state
    always_comb begin
        state_d = state_q;
        if (base_wr) begin
            state_d = cfg_zero ? XS_OFF : XS_WAIT;
        end else begin
            unique case (state_q)
                XS_OFF: begin
                    if (!cfg_zero) state_d = XS_WAIT;
                end
                XS_WAIT: begin
                    if (cfg_zero)       state_d = XS_OFF;
                    else if (res_valid) state_d = XS_WRITE;
                end
                XS_WRITE: begin
                    if (mem_ready) begin
                        if (run_end && !cfg_cont) state_d = XS_DONE;
                        else                      state_d = XS_WAIT;
                    end
                end
                XS_DONE: state_d = XS_DONE;
                default: state_d = XS_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_OFF;
        else        state_q <= state_d;
    end

    // decoded controls
    assign mem_valid = (state_q == XS_WRITE);
    assign active    = (state_q == XS_WAIT) || (state_q == XS_WRITE);
    assign adv       = mem_valid && mem_ready && !base_wr;
    assign rewind    = (state_q == XS_OFF) && !cfg_zero && !base_wr;
    assign take      = (state_q == XS_WAIT) && !cfg_zero && res_valid && !base_wr;
    assign drop      = mem_valid && res_valid;
    assign mem_data  = data_q;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            blk_done <= 1'b0;
            last_blk <= 1'b0;
        end else begin
            blk_done <= adv && blk_end;
            if (take) data_q <= res_data;
            if (base_wr)             last_blk <= 1'b0;
            else if (adv && blk_end) last_blk <= blk_idx;
        end
    end
endmodule

// File: rtl/adc_xfer_ctl.sv
// Top: per-sample block transfer engine with one/two-block buffering.
module adc_xfer_ctl
    import adc_xfer_pkg::*;
#(
    parameter int unsigned AW      = XFER_AW,
    parameter int unsigned DW      = XFER_DW,
    parameter int unsigned CW      = XFER_CW,
    parameter int unsigned STEP    = XFER_STEP,
    parameter logic [AW-1:0] BASE_RV = XFER_BASE_RV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_dual,
    input  logic          cfg_cont,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ready,
    output logic          blk_done,
    output logic          last_blk,
    output logic          overrun,
    output logic          active
);
    logic cfg_zero;
    logic adv, rewind, drop;
    logic blk_idx, blk_end, run_end;

    assign cfg_zero = (cfg_count == '0);

    adc_xfer_ptr #(
        .AW(AW), .CW(CW), .STEP(STEP), .BASE_RV(BASE_RV)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(base_wr), .load_addr(base_wdata),
        .rewind(rewind), .adv(adv),
        .cfg_count(cfg_count), .cfg_dual(cfg_dual),
        .ptr(mem_addr), .blk_idx(blk_idx),
        .blk_end(blk_end), .run_end(run_end)
    );

    adc_xfer_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .base_wr(base_wr), .cfg_zero(cfg_zero), .cfg_cont(cfg_cont),
        .res_valid(res_valid), .res_data(res_data), .mem_ready(mem_ready),
        .blk_end(blk_end), .run_end(run_end), .blk_idx(blk_idx),
        .mem_valid(mem_valid), .mem_data(mem_data),
        .adv(adv), .rewind(rewind), .drop(drop),
        .blk_done(blk_done), .last_blk(last_blk), .active(active)
    );

    adc_xfer_flag u_ovr (
        .clk(clk), .rst_n(rst_n),
        .set(drop), .clr(base_wr), .q(overrun)
    );
endmodule

// File: rtl/adc_xfer_chk.sv
module adc_xfer_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          base_wr,
    input logic          res_valid,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic          blk_done,
    input logic          overrun,
    input logic          active
);
    assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !base_wr) |=>
        (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> $past(mem_valid && mem_ready));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_valid);

    assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && res_valid && !base_wr) |=> overrun);

    assert_ovr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !base_wr) |=> overrun);
endmodule

bind adc_xfer_ctl adc_xfer_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .res_valid(res_valid),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .blk_done(blk_done), .overrun(overrun), .active(active)
);

// File: tb/adc_xfer_ctl_test.sv
module adc_xfer_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_count = 8'd0;
    logic        cfg_dual = 1'b0;
    logic        cfg_cont = 1'b0;
    logic        base_wr = 1'b0;
    logic [15:0] base_wdata = 16'h0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = 16'h0;
    logic        mem_ready = 1'b1;
    logic        mem_valid, blk_done, last_blk, overrun, active;
    logic [15:0] mem_addr, mem_data;

    int nchk = 0;
    int nfail = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    logic [15:0] last_addr = 16'hFFFF;
    logic [15:0] last_data = 16'hFFFF;

    always #2 clk = ~clk;

    adc_xfer_ctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_dual(cfg_dual),
        .cfg_cont(cfg_cont), .base_wr(base_wr), .base_wdata(base_wdata),
        .res_valid(res_valid), .res_data(res_data), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
        .blk_done(blk_done), .last_blk(last_blk), .overrun(overrun), .active(active)
    );

    // handshake / pulse monitor, sampled before the edge updates them
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= mem_addr;
            last_data <= mem_data;
        end
        if (rst_n && blk_done) done_cnt <= done_cnt + 1;
    end

    typedef struct packed {
        logic [7:0]  cnt;
        logic        dual;
        logic        cont;
        logic [15:0] base;
        logic [7:0]  nres;
        logic [7:0]  e_wr;
        logic [7:0]  e_done;
        logic        e_act;
        logic        e_lb;
        logic [15:0] e_addr;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd3, 1'b0, 1'b0, 16'h0100, 8'd5, 8'd3, 8'd1, 1'b0, 1'b0, 16'h0104}, // R5
        '{8'd2, 1'b1, 1'b0, 16'h0300, 8'd6, 8'd4, 8'd2, 1'b0, 1'b1, 16'h0306}, // R6
        '{8'd2, 1'b0, 1'b1, 16'h0400, 8'd5, 8'd5, 8'd2, 1'b1, 1'b0, 16'h0400}, // R7
        '{8'd1, 1'b1, 1'b1, 16'h0010, 8'd3, 8'd3, 8'd3, 1'b1, 1'b0, 16'h0010}, // R6 R7
        '{8'd0, 1'b0, 1'b1, 16'h0500, 8'd3, 8'd0, 8'd0, 1'b0, 1'b0, 16'hFFFF}  // R2
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clr_mon();
        wr_cnt    = 0;
        done_cnt  = 0;
        last_addr = 16'hFFFF;
        last_data = 16'hFFFF;
    endtask

    task automatic write_base(input logic [15:0] a);
        base_wr = 1'b1; base_wdata = a;
        tick();
        base_wr = 1'b0;
    endtask

    // one-cycle sample strobe, then room for the write to finish
    task automatic send(input logic [15:0] d);
        res_valid = 1'b1; res_data = d;
        tick();
        res_valid = 1'b0;
        repeat (3) tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 mem_valid", mem_valid, 0);
        chk("R1 active", active, 0);
        chk("R1 flags", {blk_done, last_blk, overrun}, 0);
        rst_n = 1'b1;
        tick();
        // R1/R2: count goes non-zero, arms at reset start address
        cfg_count = 8'd1;
        tick();
        chk("R2 armed", active, 1);
        res_valid = 1'b1; res_data = 16'h1234;
        tick();
        res_valid = 1'b0;
        chk("R3 mem_valid next cycle", mem_valid, 1);
        chk("R1 reset start address", mem_addr, 16'h0200);
        chk("R3 data", mem_data, 16'h1234);
        tick();
        chk("R4 blk_done after last handshake", blk_done, 1);
        chk("R5 stopped", active, 0);
        send(16'h4321);
        chk("R5 ignored after stop", wr_cnt, 1);

        // vector table
        foreach (VECS[i]) begin
            cfg_count = VECS[i].cnt;
            cfg_dual  = VECS[i].dual;
            cfg_cont  = VECS[i].cont;
            write_base(VECS[i].base);
            clr_mon();
            for (int k = 0; k < int'(VECS[i].nres); k++) send(16'h5000 + 16'(k));
            repeat (2) tick();
            chk($sformatf("R4 vec%0d writes", i), wr_cnt, VECS[i].e_wr);
            chk($sformatf("R4 vec%0d blocks", i), done_cnt, VECS[i].e_done);
            chk($sformatf("R7 vec%0d active", i), active, VECS[i].e_act);
            chk($sformatf("R6 vec%0d last_blk", i), last_blk, VECS[i].e_lb);
            chk($sformatf("R3 vec%0d last addr", i), last_addr, VECS[i].e_addr);
        end

        // R9 overrun with stalled memory
        cfg_count = 8'd4; cfg_dual = 1'b0; cfg_cont = 1'b0;
        write_base(16'h0800);
        clr_mon();
        mem_ready = 1'b0;
        res_valid = 1'b1; res_data = 16'hAAAA;
        tick();
        chk("R3 addr", mem_addr, 16'h0800);
        res_data = 16'hBBBB;
        tick();
        res_valid = 1'b0;
        chk("R9 overrun set", overrun, 1);
        chk("R9 pending data kept", mem_data, 16'hAAAA);
        chk("R3 held", mem_valid, 1);
        mem_ready = 1'b1;
        repeat (3) tick();
        chk("R9 one write", wr_cnt, 1);
        chk("R9 written data", last_data, 16'hAAAA);
        chk("R9 sticky", overrun, 1);

        // R8 rewrite mid-block
        cfg_count = 8'd3;
        write_base(16'h0900);
        chk("R8 overrun cleared", overrun, 0);
        send(16'h0001);
        send(16'h0002);
        chk("R4 no pulse mid-block", done_cnt, 0);
        write_base(16'h0A00);
        clr_mon();
        res_valid = 1'b1; res_data = 16'h0003;
        tick();
        res_valid = 1'b0;
        chk("R8 new start addr", mem_addr, 16'h0A00);
        repeat (3) tick();
        send(16'h0004);
        chk("R4 no pulse at 2 of 3", done_cnt, 0);
        send(16'h0005);
        chk("R8 block counted from rewrite", done_cnt, 1);
        chk("R8 last addr", last_addr, 16'h0A04);

        // R7 clearing continuous bit
        cfg_count = 8'd1; cfg_cont = 1'b1;
        write_base(16'h0B00);
        clr_mon();
        send(16'h0010);
        chk("R7 continues", active, 1);
        cfg_cont = 1'b0;
        send(16'h0011);
        chk("R7 wrapped addr", last_addr, 16'h0B00);
        chk("R7 stops at final block", active, 0);
        send(16'h0012);
        chk("R7 no write after stop", wr_cnt, 2);

        // R2 count to zero while armed
        cfg_count = 8'd2; cfg_cont = 1'b1;
        write_base(16'h0C00);
        clr_mon();
        send(16'h0020);
        cfg_count = 8'd0;
        tick();
        chk("R2 off", active, 0);
        send(16'h0021);
        chk("R2 ignored", wr_cnt, 1);
        cfg_count = 8'd2;
        tick();
        res_valid = 1'b1; res_data = 16'h0022;
        tick();
        res_valid = 1'b0;
        chk("R2 rearm at start", mem_addr, 16'h0C00);
        repeat (3) tick();

        summary();
        $finish;
    end
endmodule